// File: doc/BRIEF.md
# Receive Descriptor Scatter Engine

This block takes received frames as a byte stream, appends a four-byte CRC-32, and places the result into a ring of receive buffer descriptors held in system memory. It refuses a frame whose full image would not fit. Before the first memory write it walks the ring from the current descriptor, and each empty descriptor it passes counts for one programmed buffer size. The frame is held in an internal staging buffer while the CRC is appended and the walk runs. When the frame fits, the engine spreads it over as many descriptors as it needs. It writes the data into each descriptor's buffer, then rewrites the descriptor's status and length word, and pulses one event per descriptor.

Each descriptor takes 8 bytes. The word at the descriptor address carries the status flags in bits 31:16 and the byte count in bits 15:0. The word at descriptor address + 4 holds the buffer address. Status bit 15 marks the descriptor empty (owned by the engine), bit 13 makes the ring wrap to its base, bit 11 marks the last descriptor of a frame, bit 5 flags a frame that is too long, and bit 0 flags a truncated frame. The memory port is 32 bits wide. A data byte for byte address A travels on lane A[1:0] (wdata bits 8*A[1:0]+7 down to 8*A[1:0]) with only that strobe bit set. Reads return data with `mem_rvalid` exactly one cycle after the request.

Configuration writes select a register with `cfg_sel`:
- 0 is control: bit 1 enables the engine, and bit 0 requests a soft reset.
- 1 is receive activation.
- 2 is receive control: bits 26:16 hold the maximum frame length.
- 3 is buffer size.
- 4 is ring base.

Writing the ring base also moves the current descriptor pointer to it.

Top module: `rx_scatter_engine`

## Requirements
- R1: After reset, `rx_en`, `mem_req`, `ev_frame` and `ev_buf` are low and `in_ready` is high; the length limit is 1518 and the buffer size is 0x7F0.
- R2: A buffer size write keeps only bits 10:4 of the value; when those bits are all zero the size becomes 0x7F0.
- R3: An activation write reads the current descriptor only while the engine is enabled and receiving is off; `rx_en` then takes the descriptor's empty bit (bit 15). Without enable it has no effect.
- R4: Writing control with bit 1 clear drops `rx_en` within two cycles. A frame that starts while `rx_en` is low is consumed and discarded with no memory write.
- R5: The stored image is the frame data followed by the CRC-32 (reflected polynomial 0xEDB88320, initial value all ones, final inversion), least significant byte first. Stored lengths count these bytes, and the CRC may straddle two descriptors.
- R6: If the walk meets a non-empty descriptor before the remaining byte count is at most one buffer size, the whole frame is dropped with no memory write, and the ring pointer and `rx_en` stay as they were.
- R7: Each descriptor receives min(remaining, buffer size) bytes at its buffer address, one strobed byte per write. Its word is rewritten with that length, the empty bit cleared, and the other flag bits kept.
- R8: The final descriptor of a frame also gets bit 11 plus the error flags, and its write pulses `ev_frame`. Every other descriptor write pulses `ev_buf`, and data writes pulse neither.
- R9: An image longer than 2032 bytes is cut to 2032 bytes and flagged with bit 0 and bit 5.
- R10: An image (after any cut) longer than the length limit sets bit 5 only.
- R11: After a descriptor with bit 13 set, the next descriptor is the ring base; otherwise it is the current address plus 8.
- R12: After each written frame, `rx_en` stays high only if the engine is enabled and the next descriptor is empty.
- R13: A control write with bit 0 set restores the default limit and buffer size and disables the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write value |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| mem_req | output | 1 | Memory access request (one cycle) |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte lane strobes |
| mem_rvalid | input | 1 | Read data valid, one cycle after a read request |
| mem_rdata | input | 32 | Read data |
| rx_en | output | 1 | Receiving enabled |
| ev_frame | output | 1 | Final descriptor of a frame written |
| ev_buf | output | 1 | Non-final descriptor written |

## Verification
The assertions rely on memory answering every read with exactly one `mem_rvalid` pulse in the following cycle and never otherwise. The bench's memory responder answers every read that way and raises `mem_rvalid` for no other reason. Configuration writes are issued only while no frame is being processed, so the ring pointer never moves under an active transfer. The bench also never edits a descriptor while the engine is walking the ring, which keeps the space check and the later write pass seeing the same ring contents.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int FLG_EMPTY = 15;
  localparam int FLG_WRAP  = 13;
  localparam int FLG_LAST  = 11;
  localparam int FLG_LONG  = 5;
  localparam int FLG_TRUNC = 0;

  localparam int SZ_W = 11;
  localparam logic [SZ_W-1:0] BSZ_DEFAULT = 11'h7F0;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_ACT   = 3'd1;
  localparam logic [2:0] SEL_RXCTL = 3'd2;
  localparam logic [2:0] SEL_BUFSZ = 3'd3;
  localparam logic [2:0] SEL_RING  = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_COLLECT, S_CRC, S_CHK_RD, S_CHK_WT,
    S_D0_RD, S_D0_WT, S_D1_RD, S_D1_WT, S_DATA, S_DWR,
    S_ARM_RD, S_ARM_WT
  } state_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/rxs_cfg.sv
module rxs_cfg #(
  parameter int ADDR_W = 32,
  parameter logic [10:0] LIM_RST = 11'd1518
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [2:0]        sel,
  input  logic [31:0]       wdata,
  output logic              ctl_en,
  output logic [10:0]       limit,
  output logic [10:0]       buf_size,
  output logic [ADDR_W-1:0] ring_base,
  output logic              ring_load,
  output logic              act_req
);
  import rxs_pkg::*;

  logic [10:0] bsz_masked;
  assign bsz_masked = {wdata[10:4], 4'b0000};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en    <= 1'b0;
      limit     <= LIM_RST;
      buf_size  <= BSZ_DEFAULT;
      ring_base <= '0;
      ring_load <= 1'b0;
      act_req   <= 1'b0;
    end else begin
      ring_load <= 1'b0;
      act_req   <= 1'b0;
      if (wr) begin
        case (sel)
          SEL_CTRL: begin
            if (wdata[0]) begin
              ctl_en   <= 1'b0;
              limit    <= LIM_RST;
              buf_size <= BSZ_DEFAULT;
            end else begin
              ctl_en <= wdata[1];
            end
          end
          SEL_ACT:   act_req  <= ctl_en;
          SEL_RXCTL: limit    <= wdata[26:16];
          SEL_BUFSZ: buf_size <= (bsz_masked == '0) ? BSZ_DEFAULT : bsz_masked;
          SEL_RING: begin
            ring_base <= {wdata[ADDR_W-1:2], 2'b00};
            ring_load <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxs_frame_buf.sv
module rxs_frame_buf #(
  parameter int DEPTH = 2032,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/rxs_crc.sv
module rxs_crc (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        start,
  input  logic [7:0]  din,
  output logic [31:0] crc_res
);
  import rxs_pkg::*;

  logic [31:0] acc;

  always_ff @(posedge clk) begin
    if (rst) acc <= '1;
    else if (en) acc <= crc_step(start ? 32'hFFFF_FFFF : acc, din);
  end

  assign crc_res = ~acc;
endmodule

// File: rtl/rx_scatter_engine.sv
module rx_scatter_engine #(
  parameter int FRAME_MAX = 2032,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter logic [10:0] LIM_RST = 11'd1518
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_wstrb,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              rx_en,
  output logic              ev_frame,
  output logic              ev_buf
);
  import rxs_pkg::*;

  localparam int BUF_AW = $clog2(FRAME_MAX);
  localparam int LEN_W  = $clog2(FRAME_MAX + 1);
  localparam int CW1    = CNT_W + 1;
  localparam logic [CW1-1:0] FMAX_X = CW1'(FRAME_MAX);

  state_t state;

  logic              ctl_en, ring_load, act_req;
  logic [10:0]       limit, buf_size;
  logic [ADDR_W-1:0] ring_base;

  logic [CNT_W-1:0]  cnt;
  logic              drop_q, arm_pend;
  logic [1:0]        crc_idx;
  logic [LEN_W-1:0]  remain, chunk, issued;
  logic              f_trunc, f_long;
  logic [ADDR_W-1:0] walk_addr, cur_ptr, dptr, pend_dst;
  logic [15:0]       dflags;
  logic [BUF_AW-1:0] rd_idx;
  logic              pend;

  logic              buf_we, buf_re;
  logic [BUF_AW-1:0] buf_wa;
  logic [7:0]        buf_wd, buf_rd;
  logic [31:0]       crc_res;

  logic              accept, keep_byte;
  logic [CW1-1:0]    wr_idx, crc_pos, sum4;
  logic              trunc_n, long_n;
  logic [LEN_W-1:0]  total_n, chunk_n;
  logic [15:0]       wflags;
  logic              last_d;

  rxs_cfg #(.ADDR_W(ADDR_W), .LIM_RST(LIM_RST)) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .ctl_en(ctl_en), .limit(limit), .buf_size(buf_size), .ring_base(ring_base),
    .ring_load(ring_load), .act_req(act_req)
  );

  rxs_frame_buf #(.DEPTH(FRAME_MAX)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_wa), .wdata(buf_wd),
    .re(buf_re), .raddr(rd_idx), .rdata(buf_rd)
  );

  rxs_crc u_crc (
    .clk(clk), .rst(rst), .en(accept), .start(state == S_IDLE),
    .din(in_data), .crc_res(crc_res)
  );

  assign in_ready  = ((state == S_IDLE) && !arm_pend) || (state == S_COLLECT);
  assign accept    = in_valid && in_ready;
  assign keep_byte = (state == S_IDLE) ? rx_en : !drop_q;
  assign wr_idx    = (state == S_IDLE) ? '0 : {1'b0, cnt};
  assign crc_pos   = {1'b0, cnt} + CW1'(crc_idx);

  always_comb begin
    buf_we = 1'b0;
    buf_wa = wr_idx[BUF_AW-1:0];
    buf_wd = in_data;
    if (state == S_CRC) begin
      buf_we = crc_pos < FMAX_X;
      buf_wa = crc_pos[BUF_AW-1:0];
      buf_wd = crc_res[8*crc_idx +: 8];
    end else if (accept && keep_byte && (wr_idx < FMAX_X)) begin
      buf_we = 1'b1;
    end
  end

  assign sum4    = {1'b0, cnt} + CW1'(4);
  assign trunc_n = sum4 > FMAX_X;
  assign total_n = trunc_n ? LEN_W'(FRAME_MAX) : sum4[LEN_W-1:0];
  assign long_n  = trunc_n || (32'(total_n) > 32'(limit));

  assign chunk_n = (32'(remain) <= 32'(buf_size)) ? remain : LEN_W'(buf_size);
  assign buf_re  = (state == S_DATA) && (issued < chunk);
  assign last_d  = (remain == chunk);

  always_comb begin
    wflags = dflags;
    wflags[FLG_EMPTY] = 1'b0;
    if (last_d) begin
      wflags[FLG_LAST]  = 1'b1;
      wflags[FLG_LONG]  = dflags[FLG_LONG] | f_long;
      wflags[FLG_TRUNC] = dflags[FLG_TRUNC] | f_trunc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      drop_q    <= 1'b0;
      arm_pend  <= 1'b0;
      crc_idx   <= '0;
      remain    <= '0;
      chunk     <= '0;
      issued    <= '0;
      f_trunc   <= 1'b0;
      f_long    <= 1'b0;
      walk_addr <= '0;
      cur_ptr   <= '0;
      dptr      <= '0;
      pend_dst  <= '0;
      dflags    <= '0;
      rd_idx    <= '0;
      pend      <= 1'b0;
      rx_en     <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_wstrb <= '0;
      ev_frame  <= 1'b0;
      ev_buf    <= 1'b0;
    end else begin
      mem_req  <= 1'b0;
      mem_we   <= 1'b0;
      ev_frame <= 1'b0;
      ev_buf   <= 1'b0;
      if (ring_load) cur_ptr <= ring_base;
      if (act_req && !rx_en) arm_pend <= 1'b1;

      case (state)
        S_IDLE: begin
          if (arm_pend) begin
            state <= S_ARM_RD;
          end else if (accept) begin
            drop_q <= !rx_en;
            cnt    <= CNT_W'(1);
            crc_idx <= '0;
            if (in_last) state <= rx_en ? S_CRC : S_IDLE;
            else         state <= S_COLLECT;
          end
        end
        S_COLLECT: begin
          if (accept) begin
            if (!(&cnt)) cnt <= cnt + 1'b1;
            crc_idx <= '0;
            if (in_last) state <= drop_q ? S_IDLE : S_CRC;
          end
        end
        S_CRC: begin
          crc_idx <= crc_idx + 1'b1;
          if (crc_idx == 2'd3) begin
            remain    <= total_n;
            f_trunc   <= trunc_n;
            f_long    <= long_n;
            walk_addr <= cur_ptr;
            state     <= S_CHK_RD;
          end
        end
        S_CHK_RD: begin
          mem_req  <= 1'b1;
          mem_addr <= walk_addr;
          state    <= S_CHK_WT;
        end
        S_CHK_WT: begin
          if (mem_rvalid) begin
            if (!mem_rdata[16+FLG_EMPTY]) begin
              state <= S_IDLE;
            end else if (32'(remain) <= 32'(buf_size)) begin
              remain <= total_n;
              rd_idx <= '0;
              state  <= S_D0_RD;
            end else begin
              remain    <= remain - LEN_W'(buf_size);
              walk_addr <= mem_rdata[16+FLG_WRAP] ? ring_base : walk_addr + ADDR_W'(8);
              state     <= S_CHK_RD;
            end
          end
        end
        S_D0_RD: begin
          mem_req  <= 1'b1;
          mem_addr <= cur_ptr;
          state    <= S_D0_WT;
        end
        S_D0_WT: begin
          if (mem_rvalid) begin
            dflags <= mem_rdata[31:16];
            state  <= S_D1_RD;
          end
        end
        S_D1_RD: begin
          mem_req  <= 1'b1;
          mem_addr <= cur_ptr + ADDR_W'(4);
          state    <= S_D1_WT;
        end
        S_D1_WT: begin
          if (mem_rvalid) begin
            dptr   <= mem_rdata[ADDR_W-1:0];
            chunk  <= chunk_n;
            issued <= '0;
            pend   <= 1'b0;
            state  <= S_DATA;
          end
        end
        S_DATA: begin
          pend <= buf_re;
          if (buf_re) begin
            issued   <= issued + 1'b1;
            rd_idx   <= rd_idx + 1'b1;
            pend_dst <= dptr + ADDR_W'(issued);
          end
          if (pend) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= pend_dst;
            mem_wdata <= {4{buf_rd}};
            mem_wstrb <= 4'b0001 << pend_dst[1:0];
          end
          if (!buf_re && !pend) state <= S_DWR;
        end
        S_DWR: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= cur_ptr;
          mem_wdata <= {wflags, 16'(chunk)};
          mem_wstrb <= 4'hF;
          ev_frame  <= last_d;
          ev_buf    <= !last_d;
          remain    <= remain - chunk;
          cur_ptr   <= dflags[FLG_WRAP] ? ring_base : cur_ptr + ADDR_W'(8);
          state     <= last_d ? S_ARM_RD : S_D0_RD;
        end
        S_ARM_RD: begin
          mem_req  <= 1'b1;
          mem_addr <= cur_ptr;
          state    <= S_ARM_WT;
        end
        S_ARM_WT: begin
          if (mem_rvalid) begin
            rx_en    <= ctl_en && mem_rdata[16+FLG_EMPTY];
            arm_pend <= 1'b0;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase

      if (!ctl_en) begin
        rx_en    <= 1'b0;
        arm_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker (
  input logic        clk,
  input logic        rst,
  input logic        ctl_en,
  input logic [10:0] buf_size,
  input logic        mem_req,
  input logic        mem_we,
  input logic [3:0]  mem_wstrb,
  input logic        mem_rvalid,
  input logic        rx_en,
  input logic        ev_frame,
  input logic        ev_buf
);
  assert_event_on_desc_R8: assert property (@(posedge clk) disable iff (rst)
    (ev_frame || ev_buf) |-> (mem_req && mem_we && mem_wstrb == 4'hF));

  assert_one_event_R8: assert property (@(posedge clk) disable iff (rst)
    !(ev_frame && ev_buf));

  assert_byte_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_wstrb != 4'hF) |-> $onehot0(mem_wstrb) && (mem_wstrb != 4'h0));

  assert_enable_after_read_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_en) |-> $past(mem_rvalid));

  assert_disable_drops_R4: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |=> !rx_en);

  assert_bufsize_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (buf_size != 11'd0) && (buf_size[3:0] == 4'd0));
endmodule

bind rx_scatter_engine rxs_checker u_rxs_checker (
  .clk(clk), .rst(rst), .ctl_en(ctl_en), .buf_size(buf_size),
  .mem_req(mem_req), .mem_we(mem_we), .mem_wstrb(mem_wstrb),
  .mem_rvalid(mem_rvalid), .rx_en(rx_en), .ev_frame(ev_frame), .ev_buf(ev_buf)
);

// File: tb/rx_scatter_engine_test.sv
module rx_scatter_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int FMAX = 2032;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, mem_req, mem_we, rx_en, ev_frame, ev_buf;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0] mem_wstrb;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  rx_scatter_engine uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wstrb(mem_wstrb), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rx_en(rx_en), .ev_frame(ev_frame), .ev_buf(ev_buf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchecks = 0, nerr = 0;
  logic [31:0] mem [int];
  logic [31:0] mdl [int];

  typedef struct { logic [31:0] addr; logic [31:0] data; logic [3:0] strb; logic evf; string req; } wr_t;
  wr_t expq[$];

  bit m_en = 0, m_rx = 0;
  int m_bsz = 32'h7F0, m_lim = 1518;
  logic [31:0] m_base = 0, m_ptr = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rdm(logic [31:0] a);
    int k = int'(a >> 2);
    return mdl.exists(k) ? mdl[k] : 32'h0;
  endfunction

  function automatic logic [31:0] rdp(logic [31:0] a);
    int k = int'(a >> 2);
    return mem.exists(k) ? mem[k] : 32'h0;
  endfunction

  // Memory responder and per-clock comparison against the expected write stream.
  always @(negedge clk) begin
    if (rst) begin
      mem_rvalid <= 1'b0;
    end else begin
      mem_rvalid <= mem_req && !mem_we;
      if (mem_req && !mem_we) mem_rdata <= rdp(mem_addr);
      if (mem_req && mem_we) begin
        logic [31:0] w;
        w = rdp(mem_addr);
        for (int l = 0; l < 4; l++) if (mem_wstrb[l]) w[8*l +: 8] = mem_wdata[8*l +: 8];
        mem[int'(mem_addr >> 2)] = w;
        if (expq.size() == 0) begin
          check(0, "R6", "unexpected write addr", mem_addr, 0);
        end else begin
          wr_t e;
          bit ok;
          e = expq.pop_front();
          ok = (mem_addr == e.addr) && (mem_wstrb == e.strb) && (ev_frame == e.evf) &&
               (ev_buf == (e.strb == 4'hF && !e.evf));
          for (int l = 0; l < 4; l++) if (e.strb[l] && mem_wdata[8*l +: 8] != e.data[8*l +: 8]) ok = 0;
          check(ok, e.req, $sformatf("write @%0h strb %0h evf %0b", mem_addr, mem_wstrb, ev_frame),
                mem_wdata, e.data);
        end
      end else if (ev_frame || ev_buf) begin
        check(0, "R8", "event without descriptor write", {ev_frame, ev_buf}, 0);
      end
    end
  end

  task automatic set_desc(int idx, logic [15:0] flg, logic [31:0] bp);
    logic [31:0] a = 32'h1000 + 32'(idx * 8);
    mem[int'(a >> 2)] = {flg, 16'h0};     mdl[int'(a >> 2)] = {flg, 16'h0};
    mem[int'(a >> 2) + 1] = bp;           mdl[int'(a >> 2) + 1] = bp;
  endtask

  task automatic fill_ring(int first, int last_i);
    for (int k = first; k <= last_i; k++)
      set_desc(k, (k == 7) ? 16'hA000 : 16'h8000, 32'h4000 + 32'(k * 32'h800));
  endtask

  task automatic cfg(logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    case (sel)
      3'd0: if (d[0]) begin m_en = 0; m_bsz = 32'h7F0; m_lim = 1518; m_rx = 0; end
            else begin m_en = d[1]; if (!m_en) m_rx = 0; end
      3'd1: if (m_en && !m_rx) m_rx = rdm(m_ptr)[31];
      3'd2: m_lim = int'(d[26:16]);
      3'd3: m_bsz = ((d & 32'h7F0) == 0) ? 32'h7F0 : int'(d & 32'h7F0);
      3'd4: begin m_base = d & ~32'h3; m_ptr = m_base; end
      default: ;
    endcase
    repeat (8) @(negedge clk);
  endtask

  task automatic push_byte(logic [31:0] a, logic [7:0] b, string req);
    wr_t e;
    logic [31:0] w;
    e.addr = a; e.data = {4{b}}; e.strb = 4'b0001 << a[1:0]; e.evf = 0; e.req = req;
    expq.push_back(e);
    w = rdm(a); w[8*a[1:0] +: 8] = b; mdl[int'(a >> 2)] = w;
  endtask

  task automatic run_frame(int n, int seed, string req);
    logic [7:0] img[$];
    logic [31:0] c, a, p;
    int total, rem, idx, ch;
    bit trunc, lng, fits;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'((seed + i * 13) & 255);
      img.push_back(b);
      c = c ^ {24'd0, b};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) img.push_back(c[8*k +: 8]);
    trunc = (n + 4) > FMAX;
    total = trunc ? FMAX : n + 4;
    lng = trunc || (total > m_lim);
    fits = 0;
    if (m_rx) begin
      a = m_ptr; rem = total;
      for (int g = 0; g < 64; g++) begin
        if (!rdm(a)[31]) break;
        if (rem <= m_bsz) begin fits = 1; break; end
        rem -= m_bsz;
        a = rdm(a)[29] ? m_base : a + 8;
      end
    end
    if (fits) begin
      p = m_ptr; rem = total; idx = 0;
      while (rem > 0) begin
        logic [15:0] f;
        logic [31:0] bp;
        wr_t e;
        bit last_d;
        f = rdm(p)[31:16]; bp = rdm(p + 4);
        ch = (rem <= m_bsz) ? rem : m_bsz;
        for (int j = 0; j < ch; j++) push_byte(bp + 32'(j), img[idx++], req);
        last_d = (rem == ch);
        f[15] = 0;
        if (last_d) begin f[11] = 1; f[5] = f[5] | lng; f[0] = f[0] | trunc; end
        e.addr = p; e.data = {f, 16'(ch)}; e.strb = 4'hF; e.evf = last_d; e.req = req;
        expq.push_back(e);
        mdl[int'(p >> 2)] = e.data;
        rem -= ch;
        p = f[13] ? m_base : p + 8;
      end
      m_ptr = p;
      m_rx = m_en && rdm(p)[31];
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = img[i]; in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    while (!in_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, req, $sformatf("pending writes after %0d-byte frame", n), expq.size(), 0);
    check(rx_en == m_rx, req, "rx_en after frame", rx_en, m_rx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(rx_en == 0, "R1", "rx_en after reset", rx_en, 0);
    check(mem_req == 0, "R1", "mem_req after reset", mem_req, 0);
    check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
    check(!ev_frame && !ev_buf, "R1", "events after reset", {ev_frame, ev_buf}, 0);

    fill_ring(0, 7);
    cfg(3'd4, 32'h1000);
    cfg(3'd3, 32'h8F);           // R2: keeps bits 10:4 -> 128
    cfg(3'd1, 0);                // R3: no effect while disabled
    check(rx_en == 0, "R3", "activation without enable", rx_en, 0);
    cfg(3'd0, 32'h2);
    cfg(3'd1, 0);
    check(rx_en == 1, "R3", "activation with enable", rx_en, 1);

    run_frame(60, 1, "R5");      // one descriptor
    run_frame(200, 2, "R7");     // two descriptors
    run_frame(126, 3, "R5");     // CRC split over two descriptors
    fill_ring(0, 4);
    run_frame(500, 4, "R11");    // wraps 5,6,7,0
    cfg(3'd2, 32'd100 << 16);
    run_frame(120, 5, "R10");    // limit only flag
    cfg(3'd2, 32'd1518 << 16);
    run_frame(400, 6, "R6");     // refused: desc 5 not empty
    run_frame(300, 7, "R12");    // next descriptor not empty -> rx_en low
    run_frame(40, 8, "R4");      // discarded while receiving is off

    fill_ring(0, 7);
    cfg(3'd4, 32'h1000);
    cfg(3'd3, 32'h5);            // R2: masked to zero -> 0x7F0
    cfg(3'd1, 0);
    check(rx_en == 1, "R3", "re-activation", rx_en, 1);
    run_frame(2100, 9, "R9");    // cut to 2032
    run_frame(2030, 10, "R9");   // CRC partly cut
    run_frame(2028, 11, "R2");   // exactly 2032 in one 0x7F0 buffer, over limit

    cfg(3'd0, 32'h0);
    check(rx_en == 0, "R4", "rx_en after disable", rx_en, 0);
    run_frame(30, 12, "R4");

    cfg(3'd3, 32'h80);
    cfg(3'd2, 32'd100 << 16);
    cfg(3'd0, 32'h3);            // R13 soft reset
    cfg(3'd1, 0);
    check(rx_en == 0, "R13", "soft reset leaves engine disabled", rx_en, 0);
    cfg(3'd0, 32'h2);
    cfg(3'd1, 0);
    check(rx_en == 1, "R13", "enable after soft reset", rx_en, 1);
    run_frame(200, 13, "R13");   // single descriptor, no long flag

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule